// File: doc/BRIEF.md
# Subcode PW Serial Readout Port

This block hands the eight subcode channel bits of each subcode frame to an external reader over a serial port that the reader clocks. An upstream decoder delivers one subcode byte per frame, with a flag marking the two sync frames that open each 98-frame block. The port keeps an internal frame timer. At each frame start it raises a frame strobe and makes the waiting byte current. It drives a block strobe for as long as the current frame is a sync frame.

The reader watches the frame strobe and then supplies rising edges on its read clock. Each edge moves the next channel bit onto the serial data output, from channel P down to channel W. Edges past the eighth give a low level until the next frame. The read clock is sampled by the system clock. A byte that arrives while a read is in progress waits in a single pending register until the following frame start. A speed select shortens the frame period for 2x and 4x playback. An enable input gives the shared pins to this port or to the text output port.

Top module: `sc_pw_port`

## Requirements
- R1: While reset is asserted and just after its release, `blk_sync`, `frm_sync` and `pw_data` are all low.
- R2: Frame starts occur every BASE_FRAME system cycles when `speed_sel` is 0, every BASE_FRAME/2 when it is 1, and every BASE_FRAME/4 when it is 2 or 3. The value present at a frame start sets the length of the frame that follows.
- R3: `frm_sync` goes high at each frame start and stays high for exactly FS_WIDTH system cycles.
- R4: After a frame start `pw_data` is low. The k-th rising read-clock edge of the frame (k = 1..8) drives bit 8-k of the current byte, so bit 7 (channel P) comes first and bit 0 (channel W) comes last.
- R5: Every rising read-clock edge after the eighth in a frame drives `pw_data` low.
- R6: A byte delivered with `sc_valid` during a frame is held pending. It does not change the bits read in that frame and becomes current at the next frame start.
- R7: If no byte was delivered since the previous frame start, the new frame presents an all-zero byte and `blk_sync` low.
- R8: `blk_sync` equals the sync flag of the current frame's byte and holds for the whole frame, so two consecutive flagged frames keep it high for exactly those two frames.
- R9: While `port_en` is low, all three outputs are low and read-clock edges are ignored. The read position within the frame is kept for when the port is enabled again.
- R10: Each rising edge of `rd_clk` advances exactly one bit, provided its high and low phases each last at least 3 system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Gives the pins to this port (high) or to the text port (low) |
| speed_sel | input | 2 | Playback speed: 0 = 1x, 1 = 2x, 2 or 3 = 4x |
| sc_valid | input | 1 | One-cycle strobe delivering a subcode byte |
| sc_byte | input | 8 | Subcode byte, bit 7 = channel P, bit 0 = channel W |
| sc_sync_frame | input | 1 | Marks the delivered byte as one of the two block sync frames |
| rd_clk | input | 1 | Reader's read clock, asynchronous to clk |
| blk_sync | output | 1 | High during the sync frames of a block |
| frm_sync | output | 1 | Frame strobe, FS_WIDTH cycles at each frame start |
| pw_data | output | 1 | Serial channel bit |

## Verification
A wrong read counter or shift register shows at the first read edge after a frame start: a bit arrives out of order, or a ninth edge returns data instead of a low level. Both appear within a few system cycles of that edge. A pending register that is loaded too early changes the bits still being read in the current frame. A lost pending flag shows as a zero byte or a missing block strobe one frame later. A wrong frame-timer reload shows as a frame period off by a whole number of cycles, which is measured between consecutive frame strobes across all speed settings.

// File: rtl/sc_pw_pkg.sv
package sc_pw_pkg;

  typedef enum logic [1:0] {
    SPD_1X  = 2'd0,
    SPD_2X  = 2'd1,
    SPD_4X  = 2'd2,
    SPD_4XB = 2'd3
  } spd_e;

  // Right-shift applied to the base frame length for a speed code.
  function automatic int unsigned spd_shift(input spd_e s);
    case (s)
      SPD_1X:  spd_shift = 0;
      SPD_2X:  spd_shift = 1;
      default: spd_shift = 2;
    endcase
  endfunction

endpackage

// File: rtl/sc_rdclk_sync.sv
module sc_rdclk_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_clk_async,
  output logic rd_rise
);

  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= rd_clk_async;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rd_rise = s2_q & ~s3_q;

  // R10: a detected edge never lasts two cycles
  assert_single_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise |=> !rd_rise);

endmodule

// File: rtl/sc_frame_timer.sv
module sc_frame_timer
  import sc_pw_pkg::*;
#(
  parameter int BASE_FRAME = 2048,
  parameter int FS_WIDTH   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] speed_sel,
  output logic       frame_tick,
  output logic       frm_pulse
);

  localparam int CNT_W = $clog2(BASE_FRAME);
  localparam int FSW_W = $clog2(FS_WIDTH + 1);
  localparam logic [CNT_W-1:0] RELOAD_1X = CNT_W'(BASE_FRAME - 1);
  localparam logic [CNT_W-1:0] RELOAD_2X = CNT_W'((BASE_FRAME >> 1) - 1);
  localparam logic [CNT_W-1:0] RELOAD_4X = CNT_W'((BASE_FRAME >> 2) - 1);
  localparam logic [FSW_W-1:0] FS_LOAD   = FSW_W'(FS_WIDTH);

  logic [CNT_W-1:0] cnt_q, cnt_d, reload;
  logic [FSW_W-1:0] fs_q, fs_d;

  always_comb begin
    case (spd_shift(spd_e'(speed_sel)))
      0:       reload = RELOAD_1X;
      1:       reload = RELOAD_2X;
      default: reload = RELOAD_4X;
    endcase
  end

  assign frame_tick = (cnt_q == '0);

  always_comb begin
    cnt_d = frame_tick ? reload : cnt_q - 1'b1;
    if (frame_tick)        fs_d = FS_LOAD;
    else if (fs_q != '0)   fs_d = fs_q - 1'b1;
    else                   fs_d = fs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD_1X;
      fs_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      fs_q  <= fs_d;
    end
  end

  assign frm_pulse = (fs_q != '0);

  // R3: strobe follows every frame start
  assert_strobe_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> frm_pulse);

  // R2: a frame start is never followed by another one at once
  assert_no_back_to_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> !frame_tick);

endmodule

// File: rtl/sc_pw_shifter.sv
module sc_pw_shifter #(
  parameter int PW_BITS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               port_en,
  input  logic               load,
  input  logic               rd_rise,
  input  logic               in_valid,
  input  logic [PW_BITS-1:0] in_byte,
  input  logic               in_sync,
  output logic               pw_bit,
  output logic               cur_sync
);

  localparam int RC_W = $clog2(PW_BITS + 1);
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(PW_BITS);

  logic [PW_BITS-1:0] pend_q, pend_d, cur_q, cur_d;
  logic               pvld_q, pvld_d, psync_q, psync_d, csync_q, csync_d;
  logic [RC_W-1:0]    rc_q, rc_d;
  logic               pw_q, pw_d;
  logic               rd_ok;

  assign rd_ok = rd_rise & port_en & ~load;

  always_comb begin
    pend_d  = pend_q;
    psync_d = psync_q;
    pvld_d  = pvld_q;
    cur_d   = cur_q;
    csync_d = csync_q;
    rc_d    = rc_q;
    pw_d    = pw_q;
    if (load) begin
      cur_d   = pvld_q ? pend_q : '0;
      csync_d = pvld_q & psync_q;
      pvld_d  = 1'b0;
      rc_d    = '0;
      pw_d    = 1'b0;
    end else if (rd_ok) begin
      if (rc_q != RC_LAST) begin
        pw_d  = cur_q[PW_BITS-1];
        cur_d = {cur_q[PW_BITS-2:0], 1'b0};
        rc_d  = rc_q + 1'b1;
      end else begin
        pw_d = 1'b0;
      end
    end
    if (in_valid) begin
      pend_d  = in_byte;
      psync_d = in_sync;
      pvld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      psync_q <= 1'b0;
      pvld_q  <= 1'b0;
      cur_q   <= '0;
      csync_q <= 1'b0;
      rc_q    <= '0;
      pw_q    <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      psync_q <= psync_d;
      pvld_q  <= pvld_d;
      cur_q   <= cur_d;
      csync_q <= csync_d;
      rc_q    <= rc_d;
      pw_q    <= pw_d;
    end
  end

  assign pw_bit   = pw_q;
  assign cur_sync = csync_q;

  // R4: a frame start leaves the serial bit low
  assert_low_after_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !pw_bit);

  // R5: edges past the last channel give a low level
  assert_zero_past_w_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && port_en && !load && rc_q == RC_LAST) |=> !pw_bit);

  // R9: disabled port keeps its read position
  assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && !load) |=> $stable(rc_q));

  // R6: pending data only moves at a frame start
  assert_cur_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !rd_ok) |=> $stable(cur_q));

endmodule

// File: rtl/sc_pw_port.sv
module sc_pw_port #(
  parameter int BASE_FRAME = 2048,
  parameter int FS_WIDTH   = 16,
  parameter int PW_BITS    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               port_en,
  input  logic [1:0]         speed_sel,
  input  logic               sc_valid,
  input  logic [PW_BITS-1:0] sc_byte,
  input  logic               sc_sync_frame,
  input  logic               rd_clk,
  output logic               blk_sync,
  output logic               frm_sync,
  output logic               pw_data
);

  logic rst_m_q, rst_s_q;
  logic frame_tick, frm_pulse, rd_rise, pw_bit, cur_sync;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  sc_rdclk_sync u_sync (
    .clk          (clk),
    .rst_n        (rst_s_q),
    .rd_clk_async (rd_clk),
    .rd_rise      (rd_rise)
  );

  sc_frame_timer #(
    .BASE_FRAME (BASE_FRAME),
    .FS_WIDTH   (FS_WIDTH)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_s_q),
    .speed_sel  (speed_sel),
    .frame_tick (frame_tick),
    .frm_pulse  (frm_pulse)
  );

  sc_pw_shifter #(
    .PW_BITS (PW_BITS)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .port_en  (port_en),
    .load     (frame_tick),
    .rd_rise  (rd_rise),
    .in_valid (sc_valid),
    .in_byte  (sc_byte),
    .in_sync  (sc_sync_frame),
    .pw_bit   (pw_bit),
    .cur_sync (cur_sync)
  );

  assign blk_sync = port_en & cur_sync;
  assign frm_sync = port_en & frm_pulse;
  assign pw_data  = port_en & pw_bit;

  // R1: outputs quiet while the internal reset is held
  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_s_q |-> (!blk_sync && !frm_sync && !pw_data));

endmodule

// File: tb/sim_sc_pw_port.sv
module sim_sc_pw_port;

  localparam int BASE = 512;
  localparam int FSW  = 8;

  logic clk, rst_n, port_en, sc_valid, sc_sync_frame, rd_clk;
  logic [1:0] speed_sel;
  logic [7:0] sc_byte;
  logic blk_sync, frm_sync, pw_data;

  int n_chk, n_fail, cyc;
  logic finished;

  sc_pw_port #(.BASE_FRAME(BASE), .FS_WIDTH(FSW), .PW_BITS(8)) u0 (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .speed_sel(speed_sel),
    .sc_valid(sc_valid), .sc_byte(sc_byte), .sc_sync_frame(sc_sync_frame),
    .rd_clk(rd_clk), .blk_sync(blk_sync), .frm_sync(frm_sync), .pw_data(pw_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_period(input logic [1:0] s);
    if (s == 2'd0) return BASE;
    if (s == 2'd1) return BASE / 2;
    return BASE / 4;
  endfunction

  function automatic logic exp_bit(input logic [7:0] b, input int k);
    if (k < 8) return b[7 - k];
    return 1'b0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic s);
    @(negedge clk);
    sc_valid = 1'b1; sc_byte = b; sc_sync_frame = s;
    @(negedge clk);
    sc_valid = 1'b0;
  endtask

  task automatic read_edge();
    rd_clk = 1'b1;
    repeat (4) @(negedge clk);
    rd_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_frame(output int stamp);
    logic prev;
    prev = frm_sync;
    stamp = -1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (frm_sync && !prev) begin
        stamp = cyc;
        break;
      end
      prev = frm_sync;
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] nb, cb;
    logic ns, nv, cs, cv;
    logic [1:0] spd_prev;
    int t_prev, t_now, k;
    n_chk = 0; n_fail = 0; cyc = 0; finished = 1'b0;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; port_en = 1'b1; speed_sel = 2'd0;
    sc_valid = 1'b0; sc_byte = '0; sc_sync_frame = 1'b0; rd_clk = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 blk", blk_sync, 0);
    check("R1 frm", frm_sync, 0);
    check("R1 pw", pw_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 pw after release", pw_data, 0);

    nb = 8'hA5; ns = 1'b0; nv = 1'b1;
    push(nb, ns);
    t_prev = 0; spd_prev = 2'd0;

    for (int f = 0; f < 16; f++) begin
      wait_frame(t_now);
      if (t_now < 0) begin
        check("R3 frame start seen", 0, 1);
        break;
      end
      if (f >= 1) check($sformatf("R2 period f%0d", f), t_now - t_prev, exp_period(spd_prev));
      t_prev = t_now;
      cb = nv ? nb : 8'h00;
      cs = nv ? ns : 1'b0;
      cv = nv;
      check($sformatf("R8 blk f%0d", f), blk_sync, cs);
      check($sformatf("R4 idle low f%0d", f), pw_data, 0);
      if (!cv) check("R7 zero frame blk", blk_sync, 0);
      repeat (FSW - 1) @(negedge clk);
      check("R3 strobe width high", frm_sync, 1);
      @(negedge clk);
      check("R3 strobe width low", frm_sync, 0);

      spd_prev = speed_sel;
      if (f == 4)  speed_sel = 2'd1;
      if (f == 9)  speed_sel = 2'd2;
      if (f == 13) speed_sel = 2'd3;

      nv = 1'b0;
      k = 0;
      for (int r = 0; r < 10; r++) begin
        read_edge();
        if (r < 8) check($sformatf("R4 bit f%0d k%0d", f, k), pw_data, exp_bit(cb, k));
        else       check($sformatf("R5 extra edge f%0d", f), pw_data, 0);
        if (!cv) check("R7 zero frame bit", pw_data, 0);
        k++;
        if (r == 2 && f != 6) begin
          // new byte arrives mid-read (R6)
          case (f)
            0: nb = 8'hFF;
            1: nb = 8'h00;
            default: nb = 8'($urandom);
          endcase
          ns = (f == 2 || f == 3);
          nv = 1'b1;
          push(nb, ns);
        end
        if (r == 1 && f == 4) begin
          port_en = 1'b0;
          repeat (2) @(negedge clk);
          check("R9 pw off", pw_data, 0);
          check("R9 blk off", blk_sync, 0);
          check("R9 frm off", frm_sync, 0);
          for (int j = 0; j < 3; j++) read_edge();
          check("R9 pw off after edges", pw_data, 0);
          port_en = 1'b1;
        end
      end
      check($sformatf("R6 blk unchanged f%0d", f), blk_sync, cs);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule